// File: doc/BRIEF.md
# Stored Register Bank with Store-Busy Status

This block holds the stored wiper settings of a multi-channel potentiometer controller: for each channel it keeps four 6-bit registers that survive a wiper change. A serial front end decodes frames and presents each completed command on a one-cycle strobe. The command names an operation, a channel, a register index and, for direct writes, a data value. The current wiper values of all channels are presented alongside it. The block stages what the command asks for. It does not touch the registers until the chip select returns high.

When the select rises after an accepted command, the block starts a modelled store. For a fixed, parameterised number of cycles it reports itself busy, and the busy flag appears in bit 0 of a status byte. At the end of that window it writes the staged values into the registers. A write-protect input that is low when the select rises discards the staged store. Commands that arrive while a store runs are dropped, and register reads during the store return the old contents.

Top module: `nv_reg_bank`

## Requirements
- R1: After reset every register of every channel reads 0; `rdData` shows register `rdReg` of channel `rdChan` combinationally.
- R2: A command with `cmdOp` = 0 (direct write) stores `wrData` into register `cmdReg` of channel `cmdChan`.
- R3: A command with `cmdOp` = 1 (single copy) stores the wiper value of channel `cmdChan`, taken from `wiperVals` slice `[c*6 +: 6]` in the cycle of the command, into register `cmdReg` of that channel.
- R4: A command with `cmdOp` = 2 (global copy) stores each channel's wiper value into its own register `cmdReg`, with all channels written in one store.
- R5: A command is accepted only when `cmdValid` is high while `selN` is low. `cmdOp` = 3 and any command while `selN` is high are ignored. No register changes until `selN` goes from low to high.
- R6: `busy` goes high in the cycle after the cycle in which `selN` is first seen high following an accepted command. It stays high for exactly STORE_CYCLES cycles. The new register contents appear on `rdData` in the same cycle that `busy` falls.
- R7: `statusByte` carries `busy` in bit 0, and bits 7:1 are always 0.
- R8: If `wpN` is low in the cycle the select rise is seen, the staged store is discarded: `busy` stays low and no register changes.
- R9: Commands received while `busy` is high are ignored, both then and at the following select rise.
- R10: While `busy` is high, `rdData` returns the contents the registers held before the store.
- R11: When several commands are accepted within one select-low frame, only the last one is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| selN | input | 1 | Chip select from the serial front end, active low |
| wpN | input | 1 | Write protect, active low; blocks stores |
| cmdValid | input | 1 | One-cycle strobe for a completed command frame |
| cmdOp | input | 2 | 0 write, 1 single copy, 2 global copy, 3 none |
| cmdChan | input | 1 | Channel addressed by the command |
| cmdReg | input | 2 | Register index addressed by the command |
| wrData | input | 6 | Data for a direct write |
| wiperVals | input | 12 | Current wiper value of each channel, channel c at bits c*6 +: 6 |
| rdChan | input | 1 | Channel for the read port |
| rdReg | input | 2 | Register index for the read port |
| rdData | output | 6 | Contents of the addressed register |
| busy | output | 1 | Store in progress |
| statusByte | output | 8 | Status response with busy in bit 0 |

## Verification
The store path is driven with direct writes, single copies and global copies, each to a different register index and channel. This separates a wrong channel mask from a wrong register decode or a wrong data source. Frames closed with write protect low, frames carrying only the reserved operation, commands sent while deselected and commands sent during a running store each have to leave the read-back unchanged; each of these exposes a separate gating fault. A frame with two commands separates last-wins staging from first-wins staging. The reference model is compared every cycle against `rdData`, `busy` and the status byte, so that an early commit or a busy window off by one cycle shows up at the exact cycle where it occurs.

// File: rtl/nv_bank_pkg.sv
package nv_bank_pkg;

  typedef enum logic [1:0] {
    OP_WRITE    = 2'd0,
    OP_COPY_ONE = 2'd1,
    OP_COPY_ALL = 2'd2,
    OP_NONE     = 2'd3
  } bankOp_e;

  typedef struct packed {
    logic capture;  // stage the current command
    logic commit;   // write staged values into the cells
  } bankStrobe_t;

endpackage

// File: rtl/nv_bank_ctrl.sv
module nv_bank_ctrl
  import nv_bank_pkg::*;
#(
  parameter int STORE_CYCLES = 20,
  localparam int CNT_W = (STORE_CYCLES < 2) ? 1 : $clog2(STORE_CYCLES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        selN,
  input  logic        wpN,
  input  logic        cmdValid,
  input  bankOp_e     cmdOp,
  output bankStrobe_t strobe,
  output logic        busy
);

  logic             selPrevQ;
  logic             pendingQ;
  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             csRise;
  logic             launch;

  assign csRise = selN && !selPrevQ;
  assign launch = csRise && pendingQ && wpN;

  always_comb begin
    strobe.capture = cmdValid && !selN && !busyQ && (cmdOp != OP_NONE);
    strobe.commit  = busyQ && (cntQ == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      selPrevQ <= 1'b1;
      pendingQ <= 1'b0;
      busyQ    <= 1'b0;
      cntQ     <= '0;
    end else begin
      selPrevQ <= selN;
      if (csRise) begin
        pendingQ <= 1'b0;
      end else if (strobe.capture) begin
        pendingQ <= 1'b1;
      end
      if (launch) begin
        busyQ <= 1'b1;
        cntQ  <= CNT_W'(STORE_CYCLES - 1);
      end else if (busyQ) begin
        if (cntQ == '0) begin
          busyQ <= 1'b0;
        end else begin
          cntQ <= cntQ - 1'b1;
        end
      end
    end
  end

  assign busy = busyQ;

endmodule

// File: rtl/nv_bank_data.sv
module nv_bank_data
  import nv_bank_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int REG_CNT = 4,
  parameter int DATA_W  = 6,
  localparam int CH_W  = (NUM_CH  < 2) ? 1 : $clog2(NUM_CH),
  localparam int REG_W = (REG_CNT < 2) ? 1 : $clog2(REG_CNT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bankStrobe_t              strobe,
  input  bankOp_e                  cmdOp,
  input  logic [CH_W-1:0]          cmdChan,
  input  logic [REG_W-1:0]         cmdReg,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [NUM_CH*DATA_W-1:0] wiperVals,
  input  logic [CH_W-1:0]          rdChan,
  input  logic [REG_W-1:0]         rdReg,
  output logic [DATA_W-1:0]        rdData
);

  logic [REG_W-1:0]         stgRegQ;
  logic [NUM_CH*DATA_W-1:0] rdFlat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stgRegQ <= '0;
    end else if (strobe.capture) begin
      stgRegQ <= cmdReg;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] cellQ [REG_CNT];
    logic              hitQ;
    logic [DATA_W-1:0] stgQ;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hitQ <= 1'b0;
        stgQ <= '0;
        for (int r = 0; r < REG_CNT; r++) begin
          cellQ[r] <= '0;
        end
      end else begin
        if (strobe.capture) begin
          hitQ <= (cmdOp == OP_COPY_ALL) || (cmdChan == CH_W'(c));
          stgQ <= (cmdOp == OP_WRITE) ? wrData : wiperVals[c*DATA_W +: DATA_W];
        end
        if (strobe.commit && hitQ) begin
          cellQ[stgRegQ] <= stgQ;
        end
      end
    end

    assign rdFlat[c*DATA_W +: DATA_W] = cellQ[rdReg];
  end

  assign rdData = rdFlat[int'(rdChan)*DATA_W +: DATA_W];

endmodule

// File: rtl/nv_reg_bank.sv
module nv_reg_bank
  import nv_bank_pkg::*;
#(
  parameter int NUM_CH       = 2,
  parameter int REG_CNT      = 4,
  parameter int DATA_W       = 6,
  parameter int STORE_CYCLES = 20,
  localparam int CH_W  = (NUM_CH  < 2) ? 1 : $clog2(NUM_CH),
  localparam int REG_W = (REG_CNT < 2) ? 1 : $clog2(REG_CNT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     selN,
  input  logic                     wpN,
  input  logic                     cmdValid,
  input  logic [1:0]               cmdOp,
  input  logic [CH_W-1:0]          cmdChan,
  input  logic [REG_W-1:0]         cmdReg,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [NUM_CH*DATA_W-1:0] wiperVals,
  input  logic [CH_W-1:0]          rdChan,
  input  logic [REG_W-1:0]         rdReg,
  output logic [DATA_W-1:0]        rdData,
  output logic                     busy,
  output logic [7:0]               statusByte
);

  bankStrobe_t strobe;
  bankOp_e     opCode;

  assign opCode = bankOp_e'(cmdOp);

  nv_bank_ctrl #(.STORE_CYCLES(STORE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .selN     (selN),
    .wpN      (wpN),
    .cmdValid (cmdValid),
    .cmdOp    (opCode),
    .strobe   (strobe),
    .busy     (busy)
  );

  nv_bank_data #(.NUM_CH(NUM_CH), .REG_CNT(REG_CNT), .DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .cmdOp     (opCode),
    .cmdChan   (cmdChan),
    .cmdReg    (cmdReg),
    .wrData    (wrData),
    .wiperVals (wiperVals),
    .rdChan    (rdChan),
    .rdReg     (rdReg),
    .rdData    (rdData)
  );

  assign statusByte = {7'b0, busy};

endmodule

// File: rtl/nv_reg_bank_chk.sv
module nv_reg_bank_chk #(
  parameter int STORE_CYCLES = 20,
  parameter int CH_W   = 1,
  parameter int REG_W  = 2,
  parameter int DATA_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              selN,
  input logic              wpN,
  input logic              busy,
  input logic [7:0]        statusByte,
  input logic [CH_W-1:0]   rdChan,
  input logic [REG_W-1:0]  rdReg,
  input logic [DATA_W-1:0] rdData
);

  int runQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runQ <= 0;
    else        runQ <= busy ? runQ + 1 : 0;
  end

  // R5
  store_after_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(selN) && !$past(selN, 2)));

  // R8
  store_needs_wp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wpN));

  // R6
  busy_window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (runQ == STORE_CYCLES));

  // R10
  old_data_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(rdChan) && $stable(rdReg)) |-> $stable(rdData));

  // R7
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(statusByte[7:1]) == 0);

endmodule

bind nv_reg_bank nv_reg_bank_chk #(
  .STORE_CYCLES(STORE_CYCLES), .CH_W(CH_W), .REG_W(REG_W), .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .selN       (selN),
  .wpN        (wpN),
  .busy       (busy),
  .statusByte (statusByte),
  .rdChan     (rdChan),
  .rdReg      (rdReg),
  .rdData     (rdData)
);

// File: tb/nv_reg_bank_bench.sv
module nv_reg_bank_bench;

  localparam int STORE = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        selN = 1'b1;
  logic        wpN = 1'b1;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic        cmdChan = 1'b0;
  logic [1:0]  cmdReg = 2'd0;
  logic [5:0]  wrData = 6'd0;
  logic [11:0] wiperVals = 12'd0;
  logic        rdChan = 1'b0;
  logic [1:0]  rdReg = 2'd0;
  logic [5:0]  rdData;
  logic        busy;
  logic [7:0]  statusByte;

  int    nChecks = 0;
  int    nFails = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  nv_reg_bank #(.STORE_CYCLES(STORE)) u_nv_reg_bank (
    .clk(clk), .rst_n(rst_n), .selN(selN), .wpN(wpN), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdChan(cmdChan), .cmdReg(cmdReg), .wrData(wrData),
    .wiperVals(wiperVals), .rdChan(rdChan), .rdReg(rdReg), .rdData(rdData),
    .busy(busy), .statusByte(statusByte)
  );

  // behavioural reference model
  int mMem [2][4];
  int mSelPrev, mPend, mBusy, mRem;
  int sOp, sCh, sReg, sW0, sW1, sD;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mMem[i, j]) mMem[i][j] = 0;
      mSelPrev = 1; mPend = 0; mBusy = 0; mRem = 0;
    end else begin
      int cap, rise;
      cap  = (cmdValid && !selN && !mBusy && cmdOp != 2'd3) ? 1 : 0;
      rise = (selN && !mSelPrev) ? 1 : 0;
      if (mBusy) begin
        mRem = mRem - 1;
        if (mRem == 0) begin
          mBusy = 0;
          if (sOp == 0) mMem[sCh][sReg] = sD;
          else if (sOp == 1) mMem[sCh][sReg] = (sCh == 0) ? sW0 : sW1;
          else begin mMem[0][sReg] = sW0; mMem[1][sReg] = sW1; end
        end
      end
      if (rise && mPend && wpN) begin mBusy = 1; mRem = STORE; end
      if (rise) mPend = 0;
      else if (cap) begin
        mPend = 1; sOp = cmdOp; sCh = cmdChan; sReg = cmdReg; sD = wrData;
        sW0 = wiperVals[5:0]; sW1 = wiperVals[11:6];
      end
      mSelPrev = selN;
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance one clock, then compare at the falling edge
  task automatic cyc();
    @(negedge clk);
    chk(curReq, rdData, mMem[rdChan][rdReg], "rdData");
    chk("R6", busy, mBusy, "busy");
    chk("R7", statusByte, mBusy, "statusByte");
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic sendCmd(input int op, input int ch, input int rg, input int d);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdChan = 1'(ch); cmdReg = 2'(rg); wrData = 6'(d);
    cyc();
    cmdValid = 1'b0;
  endtask

  task automatic frame(input int op, input int ch, input int rg, input int d);
    selN = 1'b0; cyc();
    sendCmd(op, ch, rg, d);
    cyc(); cyc();
    selN = 1'b1;
    waitN(STORE + 3);
  endtask

  task automatic peek(input string req, input int ch, input int rg, input int exp);
    rdChan = 1'(ch); rdReg = 2'(rg);
    #1;
    chk(req, rdData, exp, "stored value");
  endtask

  initial begin : watchdog
    #2000000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 0);
    $finish;
  end

  initial begin
    waitN(3);
    rst_n = 1'b1;
    // R1: reset contents across all addresses
    curReq = "R1";
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 4; r++) begin
        rdChan = 1'(c); rdReg = 2'(r); cyc();
        chk("R1", rdData, 0, "reset value");
      end

    // R2 direct write, with R10 old data observed while busy
    curReq = "R10"; rdChan = 1'b0; rdReg = 2'd2;
    selN = 1'b0; cyc();
    sendCmd(0, 0, 2, 6'h2A);
    cyc();
    chk("R5", rdData, 0, "no change before select rise");
    selN = 1'b1; cyc(); cyc();
    chk("R7", statusByte, 1, "status while storing");
    chk("R10", rdData, 0, "old data during store");
    waitN(STORE + 2);
    peek("R2", 0, 2, 6'h2A);

    // R3 single copy of channel 1 wiper
    curReq = "R3"; wiperVals = {6'h33, 6'h15};
    frame(1, 1, 3, 0);
    wiperVals = 12'd0;
    peek("R3", 1, 3, 6'h33);
    peek("R3", 0, 3, 0);

    // R4 global copy into register 0 of both channels
    curReq = "R4"; wiperVals = {6'h3F, 6'h07};
    frame(2, 0, 0, 0);
    wiperVals = 12'd0;
    peek("R4", 0, 0, 6'h07);
    peek("R4", 1, 0, 6'h3F);

    // R8 write protect low at select rise
    curReq = "R8"; wpN = 1'b0;
    frame(0, 0, 1, 6'h11);
    wpN = 1'b1;
    peek("R8", 0, 1, 0);

    // R5 reserved opcode and command while deselected
    curReq = "R5";
    frame(3, 1, 1, 6'h05);
    peek("R5", 1, 1, 0);
    sendCmd(0, 1, 2, 6'h09);
    selN = 1'b0; cyc(); selN = 1'b1; waitN(STORE + 3);
    peek("R5", 1, 2, 0);

    // R9 command during a running store is dropped
    curReq = "R9";
    selN = 1'b0; cyc();
    sendCmd(0, 0, 3, 6'h0C);
    selN = 1'b1; cyc(); cyc();
    selN = 1'b0; cyc();
    sendCmd(0, 1, 1, 6'h22);
    selN = 1'b1; waitN(2 * STORE + 4);
    peek("R9", 0, 3, 6'h0C);
    peek("R9", 1, 1, 0);

    // R11 two commands in one frame, last wins
    curReq = "R11";
    selN = 1'b0; cyc();
    sendCmd(0, 0, 1, 6'h01);
    sendCmd(0, 1, 2, 6'h3C);
    selN = 1'b1; waitN(STORE + 3);
    peek("R11", 1, 2, 6'h3C);
    peek("R11", 0, 1, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule